// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block holds one link reservation for a single processor and decides whether a store-conditional may write memory. A load-linked request saves a word-aligned address and marks the reservation as live. Several things end the reservation: a write by another agent that hits the reserved word (or the reserved 4 KB page, if the block is built that way), an exception or exception return, a taken branch, any other load or store, any store-conditional, and more than a set number of retired instructions since the load-linked.

A store-conditional gets its answer one cycle after the request. `sc_ok` high means the store may be committed and software sees 1. Low means the store is dropped and software sees 0. Load-linked and store-conditional share the address input `acc_addr`. Only one of `ll_req` and `sc_req` is raised in a given cycle.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked or store-conditional whose address has a nonzero value in bits [1:0] drives `align_err` high for one cycle in the next cycle. It does not load, clear or otherwise alter the reservation. A misaligned store-conditional always answers `sc_ok`=0.
- R2: Each cycle with `sc_req` high is followed in the next cycle by `sc_done` high for exactly one cycle. `sc_done` is low in every other cycle.
- R3: A store-conditional succeeds (`sc_ok`=1) only when three things hold: the reservation is live, the request's word address (bits above [1:0]) equals the reserved word address, and none of the breaking events of R4, R7 or R8 happens in the same cycle. A store-conditional to a different word fails.
- R4: An external write (`snoop_wr`) that matches the reservation at the configured granularity clears the reservation. No write data takes part in the decision, so a write of an unchanged value breaks the reservation as well.
- R5: With parameter GRAN = GRAN_WORD, a snoop matches only when address bits above [1:0] are equal. With GRAN = GRAN_PAGE, a snoop matches when bits above [11:0] are equal, so a write to another word of the same 4 KB page breaks the reservation. A write to a different page never does.
- R6: Any aligned store-conditional clears the reservation, whether it succeeds or fails. Later store-conditionals fail until a new load-linked.
- R7: `exc_event` (exception entry or return) clears the reservation. If it coincides with a load-linked, the new reservation does not start.
- R8: `br_taken` or `mem_other` (another load or store) clears the reservation.
- R9: The block counts `retire` pulses after the load-linked while the reservation is live. The reservation survives exactly MAX_INSTR pulses and is cleared by pulse MAX_INSTR+1.
- R10: An aligned load-linked while a reservation is live replaces the reserved address and restarts the retire count from zero.
- R11: When a matching snoop write and a store-conditional arrive in the same cycle, the store-conditional fails. A matching snoop in the same cycle as a load-linked leaves the new reservation cleared.
- R12: Asynchronous active-low reset clears the reservation and the retire count, and holds `sc_done`, `sc_ok` and `align_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ll_req | input | 1 | Load-linked request |
| sc_req | input | 1 | Store-conditional request |
| acc_addr | input | ADDR_W | Byte address of the load-linked or store-conditional |
| retire | input | 1 | One instruction retired this cycle |
| br_taken | input | 1 | A branch was taken |
| mem_other | input | 1 | Some other load or store was performed |
| exc_event | input | 1 | Exception taken or exception return |
| snoop_wr | input | 1 | Write by another agent observed |
| snoop_addr | input | ADDR_W | Byte address of the observed write |
| sc_done | output | 1 | Store-conditional answer valid |
| sc_ok | output | 1 | Store-conditional succeeded; the write may commit |
| align_err | output | 1 | Previous request was misaligned |

## Verification
The bench builds two instances from the same stimulus. The first uses word granularity and MAX_INSTR = 12, so the retire limit and its off-by-one boundary are reached within a few dozen cycles. The second uses page granularity with the default limit of 512, so the same snoop to a neighbouring word in the same page gives opposite answers on the two instances. A behavioural model with its own parameters tracks each instance on every clock during directed scenarios and a long random phase in which requests, snoops and breaking events overlap.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [0:0] {
    GRAN_WORD = 1'b0,
    GRAN_PAGE = 1'b1
  } gran_e;
endpackage

// File: rtl/llsc_addr_cmp.sv
module llsc_addr_cmp #(
  parameter int ADDR_W = 32,
  parameter int LSB    = 2
) (
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [ADDR_W-1:0] b_addr,
  output logic              same
);
  generate
    if (LSB >= ADDR_W) begin : g_all
      assign same = 1'b1;
    end else begin : g_cmp
      assign same = (a_addr[ADDR_W-1:LSB] == b_addr[ADDR_W-1:LSB]);
    end
  endgenerate
endmodule

// File: rtl/llsc_age_ctr.sv
module llsc_age_ctr #(
  parameter int MAX_INSTR = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic step,
  output logic at_limit
);
  localparam int CW = $clog2(MAX_INSTR + 1);
  localparam logic [CW-1:0] LIM = CW'(MAX_INSTR);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign at_limit = (cnt_q == LIM);
  assign cnt_en   = restart | (step & ~at_limit);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)               cnt_d = '0;
    else if (step & ~at_limit) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM); // R9
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/llsc_resv.sv
module llsc_resv #(
  parameter int RW = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic          set_live,
  input  logic          clr,
  input  logic [RW-1:0] word_d,
  output logic          live_q,
  output logic [RW-1:0] word_q
);
  logic live_d;
  logic live_en;

  assign live_en = set_en | clr;

  always_comb begin
    live_d = live_q;
    if (set_en)   live_d = set_live;
    else if (clr) live_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       live_q <= 1'b0;
    else if (live_en) live_q <= live_d;
  end

  always_ff @(posedge clk) begin
    if (set_en) word_q <= word_d;
  end

  AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (word_q == $past(word_d))); // R10
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int    ADDR_W     = 32,
  parameter int    WORD_BYTES = 4,
  parameter int    PAGE_BYTES = 4096,
  parameter int    MAX_INSTR  = 512,
  parameter gran_e GRAN       = GRAN_WORD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll_req,
  input  logic              sc_req,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              retire,
  input  logic              br_taken,
  input  logic              mem_other,
  input  logic              exc_event,
  input  logic              snoop_wr,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              sc_done,
  output logic              sc_ok,
  output logic              align_err
);
  localparam int WORD_LSB = $clog2(WORD_BYTES);
  localparam int PAGE_LSB = $clog2(PAGE_BYTES);
  localparam int SNP_LSB  = (GRAN == GRAN_PAGE) ? PAGE_LSB : WORD_LSB;
  localparam int RW       = ADDR_W - WORD_LSB;

  logic              resv_live;
  logic [RW-1:0]     resv_word;
  logic [ADDR_W-1:0] resv_full;
  logic              snp_old_eq, snp_new_eq, sc_eq;
  logic              aligned, ll_go, sc_go;
  logic              snoop_hit, kill, age_out, at_limit, age_step;
  logic              sc_pass, set_live, clr;
  logic              done_d, ok_d, aerr_d;

  assign resv_full = {resv_word, {WORD_LSB{1'b0}}};

  llsc_addr_cmp #(.ADDR_W(ADDR_W), .LSB(SNP_LSB)) u_snp_old (
    .a_addr(snoop_addr), .b_addr(resv_full), .same(snp_old_eq));
  llsc_addr_cmp #(.ADDR_W(ADDR_W), .LSB(SNP_LSB)) u_snp_new (
    .a_addr(snoop_addr), .b_addr(acc_addr), .same(snp_new_eq));
  llsc_addr_cmp #(.ADDR_W(ADDR_W), .LSB(WORD_LSB)) u_sc_cmp (
    .a_addr(acc_addr), .b_addr(resv_full), .same(sc_eq));

  assign aligned   = (acc_addr[WORD_LSB-1:0] == '0);
  assign ll_go     = ll_req & aligned;
  assign sc_go     = sc_req & aligned & ~ll_req;
  assign snoop_hit = snoop_wr & resv_live & snp_old_eq;
  assign kill      = snoop_hit | exc_event | br_taken | mem_other;
  assign age_step  = resv_live & retire;
  assign age_out   = age_step & at_limit;
  assign sc_pass   = sc_go & resv_live & sc_eq & ~kill;
  assign set_live  = ~((snoop_wr & snp_new_eq) | exc_event);
  assign clr       = sc_go | kill | age_out;

  llsc_age_ctr #(.MAX_INSTR(MAX_INSTR)) u_age (
    .clk(clk), .rst_n(rst_n), .restart(ll_go), .step(age_step),
    .at_limit(at_limit));

  llsc_resv #(.RW(RW)) u_resv (
    .clk(clk), .rst_n(rst_n), .set_en(ll_go), .set_live(set_live),
    .clr(clr), .word_d(acc_addr[ADDR_W-1:WORD_LSB]),
    .live_q(resv_live), .word_q(resv_word));

  always_comb begin
    done_d = sc_req;
    ok_d   = sc_pass;
    aerr_d = (ll_req | sc_req) & ~aligned;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_done   <= 1'b0;
      sc_ok     <= 1'b0;
      align_err <= 1'b0;
    end else begin
      sc_done   <= done_d;
      sc_ok     <= ok_d;
      align_err <= aerr_d;
    end
  end

  AST_SC_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    sc_req |=> sc_done); // R2
  AST_OK_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && !resv_live) |=> !sc_ok); // R3
  AST_SC_ENDS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && aligned && !ll_req) |=> !resv_live); // R6
  AST_SNOOP_BEATS_SC: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && snoop_hit) |=> !sc_ok); // R11
  AST_EXC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    exc_event |=> !resv_live); // R7
  AST_BRANCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((br_taken || mem_other) && !ll_req) |=> !resv_live); // R8
  AST_MISALIGN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((ll_req || sc_req) && !aligned && !kill && !age_out) |=> $stable(resv_live)); // R1
  AST_MISALIGN_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && !aligned) |=> (align_err && !sc_ok)); // R1
endmodule

// File: tb/sim_llsc_monitor.sv
module sim_llsc_monitor;
  import llsc_pkg::*;

  localparam int LIM0 = 12;
  localparam int LIM1 = 512;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ll, sc, rt, br, om, ex, sw;
  logic [31:0] a, sa;
  logic        d0, k0, e0, d1, k1, e1;

  int total = 0;
  int bad   = 0;
  bit over  = 0;

  always #10 clk = ~clk;

  llsc_monitor #(.MAX_INSTR(LIM0), .GRAN(GRAN_WORD)) u0 (
    .clk(clk), .rst_n(rst_n), .ll_req(ll), .sc_req(sc), .acc_addr(a),
    .retire(rt), .br_taken(br), .mem_other(om), .exc_event(ex),
    .snoop_wr(sw), .snoop_addr(sa), .sc_done(d0), .sc_ok(k0), .align_err(e0));

  llsc_monitor #(.MAX_INSTR(LIM1), .GRAN(GRAN_PAGE)) u1 (
    .clk(clk), .rst_n(rst_n), .ll_req(ll), .sc_req(sc), .acc_addr(a),
    .retire(rt), .br_taken(br), .mem_other(om), .exc_event(ex),
    .snoop_wr(sw), .snoop_addr(sa), .sc_done(d1), .sc_ok(k1), .align_err(e1));

  // behavioural reference, index 0 = word/12, index 1 = page/512
  bit          mv[2];
  int unsigned ma[2];
  int          mc[2];
  bit          xd[2], xk[2], xe[2];

  function automatic bit same(int unsigned p, int unsigned q, int sh);
    return (p >> sh) == (q >> sh);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        mv[i] = 0; mc[i] = 0; xd[i] = 0; xk[i] = 0; xe[i] = 0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        int  sh, lim;
        bit  al, hit, brk, nv;
        sh  = (i == 0) ? 2 : 12;
        lim = (i == 0) ? LIM0 : LIM1;
        al  = (a[1:0] == 2'b00);
        hit = sw && mv[i] && same(sa, ma[i], sh);
        brk = hit || ex || br || om;
        xd[i] = sc;
        xe[i] = (ll || sc) && !al;
        xk[i] = sc && !ll && al && mv[i] && same(a, ma[i], 2) && !brk;
        nv = mv[i];
        if (ll && al) begin
          nv = !((sw && same(sa, a, sh)) || ex);
          ma[i] = a;
          mc[i] = 0;
        end else begin
          if (sc && al) nv = 0;
          else if (brk) nv = 0;
          else if (mv[i] && rt && mc[i] == lim) nv = 0;
          if (mv[i] && rt && mc[i] < lim) mc[i]++;
        end
        mv[i] = nv;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !over) begin
      total++;
      if ({d0, k0, e0} !== {xd[0], xk[0], xe[0]}) begin
        bad++;
        $display("FAIL R2/R3 model u0 act=%b exp=%b", {d0, k0, e0}, {xd[0], xk[0], xe[0]});
      end
      total++;
      if ({d1, k1, e1} !== {xd[1], xk[1], xe[1]}) begin
        bad++;
        $display("FAIL R2/R3 model u1 act=%b exp=%b", {d1, k1, e1}, {xd[1], xk[1], xe[1]});
      end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit l, bit s, logic [31:0] ad, bit w, logic [31:0] wa,
                      bit r, bit b, bit o, bit e);
    ll = l; sc = s; a = ad; sw = w; sa = wa; rt = r; br = b; om = o; ex = e;
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic do_ll(logic [31:0] ad);
    step(1, 0, ad, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic do_sc(logic [31:0] ad);
    step(0, 1, ad, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic snoop(logic [31:0] wa);
    step(0, 0, 0, 1, wa, 0, 0, 0, 0);
  endtask
  task automatic retire_n(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 1, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!over) begin
      over = 1;
      bad++;
      total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    ll = 0; sc = 0; a = 0; sw = 0; sa = 0; rt = 0; br = 0; om = 0; ex = 0;
    repeat (3) @(negedge clk);
    chk("R12 reset done", d0, 0);
    chk("R12 reset ok", k0, 0);
    chk("R12 reset aerr", e0, 0);
    rst_n = 1;
    idle();
    do_sc(32'h100);
    chk("R12 no resv after reset", k0, 0);
    chk("R2 done", d0, 1);
    idle();
    chk("R2 done one cycle", d0, 0);

    do_ll(32'h100); do_sc(32'h100);
    chk("R3 success", k0, 1);
    chk("R3 success u1", k1, 1);
    do_sc(32'h100);
    chk("R6 second sc fails", k0, 0);

    do_ll(32'h100); snoop(32'h100); do_sc(32'h100);
    chk("R4 same word snoop", k0, 0);
    chk("R4 same word snoop u1", k1, 0);

    do_ll(32'h100); snoop(32'h104); do_sc(32'h100);
    chk("R5 word mode other word", k0, 1);
    chk("R5 page mode same page", k1, 0);
    do_ll(32'h100); snoop(32'h2100); do_sc(32'h100);
    chk("R5 other page u1", k1, 1);

    do_ll(32'h100); step(0, 0, 0, 0, 0, 0, 0, 0, 1); do_sc(32'h100);
    chk("R7 exception", k0, 0);
    do_ll(32'h100); step(0, 0, 0, 0, 0, 0, 1, 0, 0); do_sc(32'h100);
    chk("R8 branch", k0, 0);
    do_ll(32'h100); step(0, 0, 0, 0, 0, 0, 0, 1, 0); do_sc(32'h100);
    chk("R8 other access", k0, 0);

    do_ll(32'h100); do_sc(32'h104);
    chk("R3 other address", k0, 0);

    do_ll(32'h100); do_ll(32'h102);
    chk("R1 ll misaligned", e0, 1);
    do_sc(32'h100);
    chk("R1 resv kept after bad ll", k0, 1);
    do_ll(32'h100); do_sc(32'h101);
    chk("R1 sc misaligned err", e0, 1);
    chk("R1 sc misaligned fails", k0, 0);
    do_sc(32'h100);
    chk("R1 resv kept after bad sc", k0, 1);

    do_ll(32'h100); retire_n(LIM0); do_sc(32'h100);
    chk("R9 limit reached", k0, 1);
    do_ll(32'h100); retire_n(LIM0 + 1); do_sc(32'h100);
    chk("R9 limit exceeded", k0, 0);
    chk("R9 u1 larger limit", k1, 1);

    do_ll(32'h100); do_ll(32'h200); do_sc(32'h100);
    chk("R10 old address dropped", k0, 0);
    do_ll(32'h100); do_ll(32'h200); do_sc(32'h200);
    chk("R10 new address", k0, 1);
    do_ll(32'h100); retire_n(10); do_ll(32'h100); retire_n(10); do_sc(32'h100);
    chk("R10 count restart", k0, 1);

    do_ll(32'h100); step(0, 1, 32'h100, 1, 32'h100, 0, 0, 0, 0);
    chk("R11 snoop wins", k0, 0);
    step(1, 0, 32'h100, 1, 32'h100, 0, 0, 0, 0); do_sc(32'h100);
    chk("R11 snoop with ll", k0, 0);

    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [31:0] pick [6];
      pick[0] = 32'h100; pick[1] = 32'h104; pick[2] = 32'h102;
      pick[3] = 32'h2100; pick[4] = 32'h1ffc; pick[5] = 32'h200;
      op = $urandom_range(0, 9);
      step(op < 2, (op == 2) || (op == 3), pick[$urandom_range(0, 5)],
           $urandom_range(0, 7) == 0, pick[$urandom_range(0, 5)],
           $urandom_range(0, 1) == 1, $urandom_range(0, 19) == 0,
           $urandom_range(0, 19) == 0, $urandom_range(0, 29) == 0);
    end
    idle();

    over = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule